// File: doc/BRIEF.md
# Interrupt Arbiter with Low-Power Wake

This block sequences interrupt entry for a small 8-bit style processor core. It watches reset, a software-interrupt strobe from the instruction decoder, an external request line, two timer flags that share one service vector, and a custom periodic request. At each instruction boundary it picks one event by fixed priority and emits a one-cycle take pulse with the 16-bit address of the vector pair to fetch. On the same cycle it tells the core to set the interrupt mask bit.

The block also owns the two low-power states. A stop command shuts the oscillator enable and all clock enables, and only an unmasked external request or reset brings the core back. A wait command halts the CPU clock enable while the oscillator and timer clock keep running, and an unmasked external or timer request ends it. A wake-up goes straight into the waking source's normal vector. The wait state has no vectors of its own.

Top module: `irq_seq_top`

## Requirements
- R1: While `rst` is high, on the next edge `vec_addr` becomes 16'h1FFE, `set_mask` is 1, `take` is 0, and the block is in run mode (`in_stop`=0, `in_wait`=0, `osc_en`=`cpu_clk_en`=`tmr_clk_en`=1). Reset clears a stop or wait state in that same edge.
- R2: In run mode, `boundary`=1 with `swi_strobe`=1 gives `take`=1 and `vec_addr`=16'h1FFC one cycle later, whatever the value of `mask_in`. The software interrupt outranks every hardware request.
- R3: The hardware vectors are as follows. `ext_req` uses 16'h1FFA. `tof_req` or `rti_req` uses 16'h1FF8, one shared vector. `cpi_req` uses 16'h1FF6.
- R4: When several hardware requests are pending together, the external request wins over the timer flags, and the timer flags win over the periodic request.
- R5: With `mask_in`=1, no hardware request is taken, and none wakes the block from stop or wait.
- R6: In run mode a hardware request is accepted only in a cycle with `boundary`=1. Every acceptance gives a one-cycle `take` with `set_mask`=1 in the same cycle.
- R7: `stop_cmd` in run mode, in a cycle where nothing is taken, enters stop on the next edge: `in_stop`=1 and `osc_en`=`cpu_clk_en`=`tmr_clk_en`=0.
- R8: Only an unmasked `ext_req` leaves stop. It returns to run mode with `take`=1 and `vec_addr`=16'h1FFA. Timer and periodic requests are ignored while stopped.
- R9: `wait_cmd` in run mode, in a cycle where nothing is taken and there is no `stop_cmd`, enters wait: `in_wait`=1, `cpu_clk_en`=0, `osc_en`=1, `tmr_clk_en`=1.
- R10: An unmasked external or timer request leaves wait through its normal vector, with external first. The periodic request does not wake the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset event |
| boundary | input | 1 | Instruction-boundary strobe |
| swi_strobe | input | 1 | Software interrupt instruction decoded |
| ext_req | input | 1 | External interrupt request |
| tof_req | input | 1 | Timer overflow flag request |
| rti_req | input | 1 | Real-time timer flag request |
| cpi_req | input | 1 | Custom periodic request |
| mask_in | input | 1 | Current interrupt mask bit |
| stop_cmd | input | 1 | Stop instruction executed |
| wait_cmd | input | 1 | Wait instruction executed |
| take | output | 1 | Interrupt entry pulse |
| vec_addr | output | 16 | Vector fetch address (high byte) |
| set_mask | output | 1 | Set the interrupt mask bit |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| tmr_clk_en | output | 1 | Timer clock enable |
| in_stop | output | 1 | Stop state active |
| in_wait | output | 1 | Wait state active |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a top vector of 16'h1FFE, and wake sets that allow only the external source in stop and the external plus timer sources in wait. With these defaults every vector address is a fixed constant that the bench can predict from the requirements. They also let the checks cover the cases where stop and wait differ, namely a timer flag that wakes from wait but not from stop, and a periodic request that wakes from neither.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_STOP = 2'd1,
    PM_WAIT = 2'd2
  } pm_mode_t;
endpackage

// File: rtl/irq_seq_prio.sv
// Fixed-priority pick: index 0 is the most urgent request.
module irq_seq_prio #(
  parameter int NUM_HW = 3,
  localparam int IW = (NUM_HW > 1) ? $clog2(NUM_HW) : 1
) (
  input  logic [NUM_HW-1:0] req,
  output logic              hit,
  output logic [IW-1:0]     idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_HW - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_seq_vec.sv
// Vector address generator: the pairs descend from the reset vector.
module irq_seq_vec #(
  parameter int          VEC_W   = 16,
  parameter int          NUM_HW  = 3,
  parameter logic [15:0] VEC_TOP = 16'h1FFE,
  localparam int IW = (NUM_HW > 1) ? $clog2(NUM_HW) : 1
) (
  input  logic             is_swi,
  input  logic [IW-1:0]    hw_idx,
  output logic [VEC_W-1:0] addr
);
  logic [VEC_W-1:0] hw_tab [NUM_HW];

  for (genvar g = 0; g < NUM_HW; g++) begin : g_tab
    assign hw_tab[g] = VEC_W'(VEC_TOP) - VEC_W'(2 * (g + 2));
  end

  always_comb begin
    if (is_swi) addr = VEC_W'(VEC_TOP) - VEC_W'(2);
    else        addr = hw_tab[hw_idx];
  end
endmodule

// File: rtl/irq_seq_pwr.sv
// Low-power mode state and clock enable decode.
module irq_seq_pwr
  import irq_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     go_stop,
  input  logic     go_wait,
  input  logic     wake,
  output pm_mode_t mode,
  output logic     osc_en,
  output logic     cpu_clk_en,
  output logic     tmr_clk_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= PM_RUN;
    end else begin
      case (mode)
        PM_RUN: begin
          if (go_stop)      mode <= PM_STOP;
          else if (go_wait) mode <= PM_WAIT;
        end
        PM_STOP, PM_WAIT: if (wake) mode <= PM_RUN;
        default: mode <= PM_RUN;
      endcase
    end
  end

  always_comb begin
    osc_en     = (mode != PM_STOP);
    cpu_clk_en = (mode == PM_RUN);
    tmr_clk_en = (mode != PM_STOP);
  end
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
  import irq_seq_pkg::*;
#(
  parameter int          VEC_W     = 16,
  parameter logic [15:0] VEC_TOP   = 16'h1FFE,
  parameter logic [2:0]  STOP_WAKE = 3'b001,
  parameter logic [2:0]  WAIT_WAKE = 3'b011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boundary,
  input  logic             swi_strobe,
  input  logic             ext_req,
  input  logic             tof_req,
  input  logic             rti_req,
  input  logic             cpi_req,
  input  logic             mask_in,
  input  logic             stop_cmd,
  input  logic             wait_cmd,
  output logic             take,
  output logic [VEC_W-1:0] vec_addr,
  output logic             set_mask,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic             tmr_clk_en,
  output logic             in_stop,
  output logic             in_wait
);
  localparam int NUM_HW = 3;
  localparam int IW     = $clog2(NUM_HW);

  pm_mode_t         mode;
  logic [NUM_HW-1:0] hw_raw, hw_ok;
  logic             hit, swi_go, take_d, go_stop, go_wait, wake;
  logic [IW-1:0]    hw_idx;
  logic [VEC_W-1:0] next_addr;

  // index 0 external, 1 shared timer, 2 periodic
  assign hw_raw = {cpi_req, tof_req | rti_req, ext_req};

  always_comb begin
    case (mode)
      PM_RUN:  hw_ok = boundary ? hw_raw : '0;
      PM_STOP: hw_ok = hw_raw & STOP_WAKE;
      PM_WAIT: hw_ok = hw_raw & WAIT_WAKE;
      default: hw_ok = '0;
    endcase
    if (mask_in) hw_ok = '0;
  end

  irq_seq_prio #(.NUM_HW(NUM_HW)) u_prio (
    .req (hw_ok),
    .hit (hit),
    .idx (hw_idx)
  );

  assign swi_go  = (mode == PM_RUN) && boundary && swi_strobe;
  assign take_d  = swi_go || hit;
  assign go_stop = (mode == PM_RUN) && stop_cmd && !take_d;
  assign go_wait = (mode == PM_RUN) && wait_cmd && !take_d && !stop_cmd;
  assign wake    = hit && (mode != PM_RUN);

  irq_seq_vec #(.VEC_W(VEC_W), .NUM_HW(NUM_HW), .VEC_TOP(VEC_TOP)) u_vec (
    .is_swi (swi_go),
    .hw_idx (hw_idx),
    .addr   (next_addr)
  );

  irq_seq_pwr u_pwr (
    .clk        (clk),
    .rst        (rst),
    .go_stop    (go_stop),
    .go_wait    (go_wait),
    .wake       (wake),
    .mode       (mode),
    .osc_en     (osc_en),
    .cpu_clk_en (cpu_clk_en),
    .tmr_clk_en (tmr_clk_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take     <= 1'b0;
      set_mask <= 1'b1;
      vec_addr <= VEC_W'(VEC_TOP);
    end else begin
      take     <= take_d;
      set_mask <= take_d;
      if (take_d) vec_addr <= next_addr;
    end
  end

  assign in_stop = (mode == PM_STOP);
  assign in_wait = (mode == PM_WAIT);
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int          VEC_W   = 16,
  parameter logic [15:0] VEC_TOP = 16'h1FFE
) (
  input logic             clk,
  input logic             rst,
  input logic             boundary,
  input logic             swi_strobe,
  input logic             ext_req,
  input logic             tof_req,
  input logic             rti_req,
  input logic             mask_in,
  input logic             take,
  input logic [VEC_W-1:0] vec_addr,
  input logic             set_mask,
  input logic             osc_en,
  input logic             in_stop,
  input logic             in_wait
);
  // R1
  rst_vector_chk: assert property (@(posedge clk)
    rst |=> (vec_addr == VEC_W'(VEC_TOP)) && set_mask && !take && !in_stop && !in_wait);

  // R2
  swi_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_stop && !in_wait && boundary && swi_strobe) |=>
      take && (vec_addr == VEC_W'(VEC_TOP) - VEC_W'(2)));

  // R4
  ext_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_stop && !in_wait && boundary && !swi_strobe && !mask_in && ext_req) |=>
      take && (vec_addr == VEC_W'(VEC_TOP) - VEC_W'(4)));

  // R5
  masked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_in && !(boundary && swi_strobe && !in_stop && !in_wait)) |=> !take);

  // R6
  take_sets_mask_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> set_mask);

  // R7
  stop_osc_off_chk: assert property (@(posedge clk) disable iff (rst)
    in_stop |-> !osc_en);

  // R8
  stop_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (in_stop && !(ext_req && !mask_in)) |=> in_stop && !take);

  // R10
  wait_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (in_wait && !(!mask_in && (ext_req || tof_req || rti_req))) |=> in_wait && !take);
endmodule

bind irq_seq_top irq_seq_chk #(.VEC_W(VEC_W), .VEC_TOP(VEC_TOP)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .boundary   (boundary),
  .swi_strobe (swi_strobe),
  .ext_req    (ext_req),
  .tof_req    (tof_req),
  .rti_req    (rti_req),
  .mask_in    (mask_in),
  .take       (take),
  .vec_addr   (vec_addr),
  .set_mask   (set_mask),
  .osc_en     (osc_en),
  .in_stop    (in_stop),
  .in_wait    (in_wait)
);

// File: tb/sim_irq_seq_top.sv
`timescale 1ns/1ps
module sim_irq_seq_top;
  logic clk = 1'b0;
  logic rst, boundary, swi_strobe, ext_req, tof_req, rti_req, cpi_req;
  logic mask_in, stop_cmd, wait_cmd;
  logic take, set_mask, osc_en, cpu_clk_en, tmr_clk_en, in_stop, in_wait;
  logic [15:0] vec_addr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_seq_top u0 (
    .clk(clk), .rst(rst), .boundary(boundary), .swi_strobe(swi_strobe),
    .ext_req(ext_req), .tof_req(tof_req), .rti_req(rti_req), .cpi_req(cpi_req),
    .mask_in(mask_in), .stop_cmd(stop_cmd), .wait_cmd(wait_cmd),
    .take(take), .vec_addr(vec_addr), .set_mask(set_mask), .osc_en(osc_en),
    .cpu_clk_en(cpu_clk_en), .tmr_clk_en(tmr_clk_en),
    .in_stop(in_stop), .in_wait(in_wait)
  );

  // {take, vec, swi, ext, tof, rti, cpi, mask}, applied in run mode with boundary=1
  localparam logic [22:0] TBL [12] = '{
    {1'b1, 16'h1FFC, 6'b100000},
    {1'b1, 16'h1FFC, 6'b100001},
    {1'b1, 16'h1FFA, 6'b010000},
    {1'b1, 16'h1FF8, 6'b001000},
    {1'b1, 16'h1FF8, 6'b000100},
    {1'b1, 16'h1FF6, 6'b000010},
    {1'b1, 16'h1FFA, 6'b011000},
    {1'b1, 16'h1FF8, 6'b001010},
    {1'b1, 16'h1FFA, 6'b010110},
    {1'b0, 16'h0000, 6'b010001},
    {1'b0, 16'h0000, 6'b000011},
    {1'b1, 16'h1FFC, 6'b110000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    rst = 0; boundary = 0; swi_strobe = 0; ext_req = 0; tof_req = 0;
    rti_req = 0; cpi_req = 0; mask_in = 0; stop_cmd = 0; wait_cmd = 0;
  endtask

  // inputs already set at a falling edge; pass one rising edge, sample at the next fall
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    idle();
    rst = 1;
    @(negedge clk);
    step();
    chk("R1 vec", 32'(vec_addr), 32'h1FFE);
    chk("R1 set_mask", 32'(set_mask), 1);
    chk("R1 take", 32'(take), 0);
    chk("R1 enables", {29'd0, osc_en, cpu_clk_en, tmr_clk_en}, 32'h7);
    idle();
    step();

    for (int i = 0; i < 12; i++) begin
      idle();
      boundary = 1;
      {swi_strobe, ext_req, tof_req, rti_req, cpi_req, mask_in} = TBL[i][5:0];
      step();
      chk($sformatf("R2/R3/R4/R5 row%0d take", i), 32'(take), 32'(TBL[i][22]));
      if (TBL[i][22]) begin
        chk($sformatf("R3 row%0d vec", i), 32'(vec_addr), 32'(TBL[i][21:6]));
        chk($sformatf("R6 row%0d set_mask", i), 32'(set_mask), 1);
      end
      idle();
      step();
      chk("R6 one-cycle take", 32'(take), 0);
    end

    // R6: no boundary, no acceptance
    idle(); ext_req = 1; step();
    chk("R6 no boundary", 32'(take), 0);

    // R7: enter stop
    idle(); stop_cmd = 1; step();
    chk("R7 in_stop", 32'(in_stop), 1);
    chk("R7 enables", {29'd0, osc_en, cpu_clk_en, tmr_clk_en}, 0);
    // R8: timer and periodic ignored, masked external ignored
    idle(); tof_req = 1; cpi_req = 1; step();
    chk("R8 timer ignored", {31'd0, in_stop}, 1);
    chk("R8 no take", 32'(take), 0);
    idle(); ext_req = 1; mask_in = 1; step();
    chk("R5 masked ext in stop", {31'd0, in_stop}, 1);
    idle(); ext_req = 1; step();
    chk("R8 wake take", 32'(take), 1);
    chk("R8 wake vec", 32'(vec_addr), 32'h1FFA);
    chk("R8 back to run", {29'd0, in_stop, osc_en, cpu_clk_en}, 32'h3);

    // R9: enter wait
    idle(); wait_cmd = 1; step();
    chk("R9 in_wait", 32'(in_wait), 1);
    chk("R9 enables", {29'd0, osc_en, cpu_clk_en, tmr_clk_en}, 32'h5);
    idle(); cpi_req = 1; step();
    chk("R10 periodic no wake", {30'd0, in_wait, take}, 32'h2);
    idle(); rti_req = 1; mask_in = 1; step();
    chk("R5 masked timer in wait", {30'd0, in_wait, take}, 32'h2);
    idle(); rti_req = 1; cpi_req = 1; step();
    chk("R10 timer wake take", 32'(take), 1);
    chk("R10 timer wake vec", 32'(vec_addr), 32'h1FF8);
    chk("R10 run again", 32'(cpu_clk_en), 1);

    // R7: stop wins over wait, and a take blocks stop
    idle(); stop_cmd = 1; wait_cmd = 1; step();
    chk("R7 stop over wait", {30'd0, in_stop, in_wait}, 32'h2);
    idle(); ext_req = 1; step();
    idle(); boundary = 1; ext_req = 1; stop_cmd = 1; step();
    chk("R7 take blocks stop", {30'd0, in_stop, take}, 32'h1);

    // R1: reset clears wait
    idle(); wait_cmd = 1; step();
    idle(); rst = 1; step();
    chk("R1 clears wait", {30'd0, in_wait, cpu_clk_en}, 32'h1);
    chk("R1 vec again", 32'(vec_addr), 32'h1FFE);
    idle(); step();

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule